// File: doc/BRIEF.md
# Page-Buffered Flash Program Controller

This block programs and erases an on-chip nonvolatile word array one page at a time. Software uses four word-wide registers. It sets a mode, loads a byte address, streams 32-bit words into a fill register, and then launches the operation. The controller holds the streamed words in a page buffer of 16 words (64 bytes). After each fill it moves its address forward by four bytes. When software launches a program, the controller merges the buffer into the array. Programming can only clear bits, so each array word becomes its old value ANDed with the buffered word.

A page erase sets every word of the addressed page to all ones. Both operations take a fixed number of cycles, and a busy flag is high while they run. Loading the address and accepting a fill also hold the busy flag for a short fixed time.

The controller checks addresses while words are filled and again when an operation is launched. A bad address aborts the operation quietly and sets a sticky error flag. Software clears that flag by writing one to it.

The array has no other write path. A combinational read port lets software verify the array contents.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, busy and the error flag are 0, both mode bits are 0, the address register is 0 and every array word is 0xFFFFFFFF.
- R2: A write to the address register (select 2) while idle loads the 32-bit byte address and makes it the current page, defined as the address with its low 6 bits cleared. It resets the page buffer to all ones and holds busy (status bit 0, select 1) for LOAD_CYC cycles.
- R3: A write to the fill register (select 3) while idle and with program mode set (control bit 0, select 0) stores the word in buffer slot address[5:2]. It adds 4 to the address register and holds busy for LOAD_CYC cycles.
- R4: A fill written while program mode is clear has no effect: the address stays unchanged, busy stays low and the buffer stays unchanged.
- R5: A fill whose address lies outside the current page is discarded. It sets the error flag (status bit 1), still adds 4 to the address and holds busy for LOAD_CYC cycles.
- R6: Writing control bit 2 (program start) together with bit 0 while idle launches a program. Busy then stays high for PROG_CYC cycles. When busy falls, every word of the current page equals its old value ANDed with its buffer slot, and the buffer returns to all ones.
- R7: A program launch is skipped, with no busy and no array change, and sets the error flag in either of two cases: the current page is at or beyond the array size (NUM_PAGES pages), or the address register is more than 64 bytes past the start of the current page.
- R8: Writing control bit 3 (erase start) together with bit 1 (erase mode) while idle erases the page selected by the address register. Busy stays high for ERASE_CYC cycles, and afterwards every word of that page is 0xFFFFFFFF. The erase is skipped and sets the error flag if the address is not page aligned or lies beyond the array.
- R9: The start bits clear themselves and always read back as 0. A start bit written without its mode bit launches nothing. If both starts are requested, program wins.
- R10: While busy is high, writes to the control, address and fill registers are ignored.
- R11: The error flag stays set until software writes 1 to status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 address, 3 fill |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (fill reads 0) |
| mem_raddr | input | AW | Array word index for verification reads |
| mem_rdata | output | 32 | Array word at mem_raddr |

## Verification
The hardest state to reach from the ports is a program launch that fails the boundary check. The only way to move the address past the end of the page is to keep filling after the page is full, and each of those fills is itself discarded with an error. The random stimulus therefore draws fill counts up to 18 from start offsets across the whole page, so some runs overrun the page and then launch. Directed cases cover exactly 16 fills and exactly 17 fills, out-of-range pages and misaligned erases. Every outcome is compared word by word against a model of the whole array.

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 8,
  parameter int LOAD_CYC   = 2,
  parameter int PROG_CYC   = 32,
  parameter int ERASE_CYC  = 64,
  localparam int WORDS     = PAGE_WORDS * NUM_PAGES,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] mem_raddr,
  output logic [31:0]   mem_rdata
);
  localparam int PWB = $clog2(PAGE_WORDS);
  localparam int PBB = PWB + 2;
  localparam int PGW = AW - PWB;
  localparam logic [31:0] PAGE_BYTES = 32'(PAGE_WORDS * 4);
  localparam logic [31:0] ROM_BYTES  = 32'(WORDS * 4);
  localparam logic [31:0] PMASK      = PAGE_BYTES - 32'd1;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + LOAD_CYC + 1);

  logic [31:0]    mem_q [WORDS];
  logic [31:0]    buf_q [PAGE_WORDS];
  logic [31:0]    addr_q, base_q;
  logic [CW-1:0]  cnt_q;
  logic [PGW-1:0] cpage_q;
  logic           prog_mode, erase_mode, perr, op_prog, op_erase;

  wire busy     = cnt_q != '0;
  wire finish   = cnt_q == CW'(1);
  wire wr_ctrl  = reg_we && reg_sel == 2'd0 && !busy;
  wire wr_addr  = reg_we && reg_sel == 2'd2 && !busy;
  wire wr_fill  = reg_we && reg_sel == 2'd3 && !busy && prog_mode;
  wire clr_err  = reg_we && reg_sel == 2'd1 && reg_wdata[1];
  wire go_prog  = wr_ctrl && reg_wdata[0] && reg_wdata[2];
  wire go_erase = wr_ctrl && reg_wdata[1] && reg_wdata[3] && !go_prog;
  wire fill_ok  = (addr_q & ~PMASK) == base_q;
  wire prog_bad = base_q >= ROM_BYTES || addr_q > base_q + PAGE_BYTES;
  wire erase_bad = addr_q >= ROM_BYTES || (addr_q & PMASK) != '0;
  wire commit   = finish && op_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; addr_q <= '0; base_q <= '0; cpage_q <= '0;
      prog_mode <= 1'b0; erase_mode <= 1'b0; perr <= 1'b0;
      op_prog <= 1'b0; op_erase <= 1'b0;
    end else begin
      if (busy) cnt_q <= cnt_q - CW'(1);
      if (finish) begin op_prog <= 1'b0; op_erase <= 1'b0; end
      if (clr_err) perr <= 1'b0;
      if (wr_ctrl) begin
        prog_mode  <= reg_wdata[0];
        erase_mode <= reg_wdata[1];
      end
      if (go_prog) begin
        if (prog_bad) perr <= 1'b1;
        else begin
          cnt_q <= CW'(PROG_CYC); op_prog <= 1'b1;
          cpage_q <= base_q[PBB +: PGW];
        end
      end
      if (go_erase) begin
        if (erase_bad) perr <= 1'b1;
        else begin
          cnt_q <= CW'(ERASE_CYC); op_erase <= 1'b1;
          cpage_q <= addr_q[PBB +: PGW];
        end
      end
      if (wr_addr) begin
        addr_q <= reg_wdata;
        base_q <= reg_wdata & ~PMASK;
        cnt_q  <= CW'(LOAD_CYC);
      end
      if (wr_fill) begin
        addr_q <= addr_q + 32'd4;
        cnt_q  <= CW'(LOAD_CYC);
        if (!fill_ok) perr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_WORDS; i++) buf_q[i] <= '1;
    end else if (wr_addr || commit) begin
      for (int i = 0; i < PAGE_WORDS; i++) buf_q[i] <= '1;
    end else if (wr_fill && fill_ok) begin
      buf_q[addr_q[PBB-1:2]] <= reg_wdata;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    wire hit = finish && cpage_q == PGW'(w / PAGE_WORDS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[w] <= '1;
      else if (hit && op_erase) mem_q[w] <= '1;
      else if (hit && op_prog) mem_q[w] <= mem_q[w] & buf_q[w % PAGE_WORDS];
    end
  end

  assign mem_rdata = mem_q[mem_raddr];

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {30'd0, erase_mode, prog_mode};
      2'd1:    reg_rdata = {30'd0, perr, busy};
      2'd2:    reg_rdata = addr_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module flash_page_prog_chk #(
  parameter int MAXRUN = 64,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic [AW-1:0] mem_raddr,
  input logic [31:0]   mem_rdata,
  input logic          busy,
  input logic          perr
);
  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else run_q <= busy ? run_q + 32'd1 : '0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perr) && !$past(reg_we && reg_sel == 2'd1 && reg_wdata[1]) |-> perr); // R11
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_sel == 2'd2 && !busy) |-> busy); // R2
  AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(mem_raddr) |-> $stable(mem_rdata)); // R6
  AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd0 |-> reg_rdata[31:2] == 30'd0); // R9
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 32'(MAXRUN)); // R8
endmodule

bind flash_page_prog flash_page_prog_chk #(
  .MAXRUN((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_raddr(mem_raddr),
  .mem_rdata(mem_rdata), .busy(busy), .perr(perr)
);

// File: tb/flash_page_prog_bench.sv
module flash_page_prog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16, NP = 8, LC = 2, PC = 32, EC = 64;
  localparam int WORDS = PW * NP, AW = $clog2(WORDS);
  localparam logic [31:0] ROM = 32'(WORDS * 4);

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_rdata;
  logic [AW-1:0] mem_raddr = 0;
  int checks = 0, errors = 0;

  logic [31:0] m_mem [WORDS];
  logic [31:0] m_buf [PW];
  logic [31:0] m_addr, m_base;
  logic m_pm, m_em, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_prog #(.PAGE_WORDS(PW), .NUM_PAGES(NP), .LOAD_CYC(LC),
    .PROG_CYC(PC), .ERASE_CYC(EC)) u_flash_page_prog (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic wr_raw(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_sel = 2'd1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d, output int n);
    wr_raw(s, d); #1; n = 0;
    while (reg_rdata[0]) begin n++; @(negedge clk); #1; end
  endtask

  function automatic bit prog_bad_f();
    return m_base >= ROM || m_addr > m_base + 32'd64;
  endfunction
  function automatic bit erase_bad_f();
    return m_addr >= ROM || m_addr[5:0] != 0;
  endfunction

  task automatic commit_model();
    for (int i = 0; i < PW; i++) begin
      m_mem[m_base[31:2] + 32'(i)] &= m_buf[i];
      m_buf[i] = '1;
    end
  endtask

  task automatic check_state(input string req);
    logic [31:0] v; int bad = 0; logic [31:0] a = 0, e = 0;
    rd(2'd1, v); chk(v[1] == m_err, req, {31'd0, v[1]}, {31'd0, m_err});
    rd(2'd2, v); chk(v == m_addr, req, v, m_addr);
    for (int i = 0; i < WORDS; i++) begin
      mem_raddr = AW'(i); #1;
      if (mem_rdata !== m_mem[i]) begin
        if (bad == 0) begin a = mem_rdata; e = m_mem[i]; end
        bad++;
      end
    end
    chk(bad == 0, req, a, e);
  endtask

  task automatic do_addr(input logic [31:0] a);
    int n;
    wr(2'd2, a, n);
    chk(n == LC, "R2 busy", n, LC);
    m_addr = a; m_base = a & ~32'd63;
    for (int i = 0; i < PW; i++) m_buf[i] = '1;
  endtask

  task automatic do_fill(input logic [31:0] d);
    int n;
    wr(2'd3, d, n);
    if (!m_pm) chk(n == 0, "R4 no busy", n, 0);
    else begin
      chk(n == LC, "R3 busy", n, LC);
      if ((m_addr & ~32'd63) == m_base) m_buf[m_addr[5:2]] = d;
      else m_err = 1;
      m_addr += 4;
    end
  endtask

  task automatic do_ctrl(input logic [31:0] d, input string req);
    int n, exp_n;
    logic [31:0] v;
    wr(2'd0, d, n);
    exp_n = 0;
    m_pm = d[0]; m_em = d[1];
    if (d[0] && d[2]) begin
      if (prog_bad_f()) m_err = 1;
      else begin exp_n = PC; commit_model(); end
    end else if (d[1] && d[3]) begin
      if (erase_bad_f()) m_err = 1;
      else begin
        exp_n = EC;
        for (int i = 0; i < PW; i++) m_mem[m_addr[31:2] + 32'(i)] = '1;
      end
    end
    chk(n == exp_n, req, n, exp_n);
    rd(2'd0, v); chk(v == {30'd0, m_em, m_pm}, "R9 readback", v, {30'd0, m_em, m_pm});
  endtask

  task automatic clear_err();
    int n;
    wr(2'd1, 32'h2, n); m_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
    for (int i = 0; i < PW; i++) m_buf[i] = '1;
    m_addr = 0; m_base = 0; m_pm = 0; m_em = 0; m_err = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    rd(2'd0, v); chk(v == 0, "R1 modes", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 status", v, 0);
    check_state("R1 array");

    // R4: fill without program mode
    do_fill(32'h0); check_state("R4");
    // R3/R6: partial page program at page 2
    do_ctrl(32'h1, "R9 mode only");
    do_addr(32'h88);
    do_fill(32'h1234_5678); do_fill(32'h0F0F_0F0F);
    check_state("R3");
    do_ctrl(32'h5, "R6 program");
    check_state("R6");
    // R6: AND behaviour on same words
    do_addr(32'h88); do_fill(32'hFFFF_0000);
    do_ctrl(32'h5, "R6 and"); check_state("R6 and");
    // R5/R7: 16 fills ok, 17 fills fails
    do_addr(32'h100);
    for (int i = 0; i < 16; i++) do_fill(32'hA5A5_0000 | 32'(i));
    do_ctrl(32'h5, "R7 exact page ok"); check_state("R6 full");
    do_addr(32'h140);
    for (int i = 0; i < 17; i++) do_fill(32'h0);
    check_state("R5 overrun");
    do_ctrl(32'h5, "R7 boundary skip"); check_state("R7 boundary");
    clear_err(); check_state("R11 clear");
    // R7 range
    do_addr(ROM + 32'h4); do_fill(32'h0);
    do_ctrl(32'h5, "R7 range skip"); check_state("R7 range");
    // R11 sticky through later good ops
    do_addr(32'h0); do_fill(32'h7); do_ctrl(32'h5, "R11 op");
    check_state("R11 sticky");
    clear_err();
    // R8 erase good and bad
    do_addr(32'h100); do_ctrl(32'hA, "R8 erase"); check_state("R8 erase");
    do_addr(32'h84); do_ctrl(32'hA, "R8 misaligned"); check_state("R8 misaligned");
    clear_err();
    do_addr(ROM); do_ctrl(32'hA, "R8 range"); check_state("R8 range");
    clear_err();
    // R9 start without mode, both starts
    do_addr(32'h0); do_ctrl(32'h4, "R9 no mode");
    do_ctrl(32'h1, "R9 mode");
    do_fill(32'h0);
    do_ctrl(32'hF, "R9 priority"); check_state("R9 priority");
    // R10: writes during busy ignored
    do_ctrl(32'h1, "R10 mode");
    do_addr(32'h1C0); do_fill(32'h00FF_00FF);
    wr_raw(2'd0, 32'h5);
    wr_raw(2'd2, 32'h40); wr_raw(2'd3, 32'h0); wr_raw(2'd0, 32'hA);
    commit_model();
    #1; while (reg_rdata[0]) begin @(negedge clk); #1; end
    check_state("R10");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind = int'($urandom_range(0, 3));
      logic [31:0] pg = $urandom_range(0, NP);
      if (kind == 0) begin
        logic [31:0] off = $urandom_range(0, 16) * 4;
        do_addr(pg * 64 + ($urandom_range(0, 7) == 0 ? 32'd64 : 32'd0) + off);
        do_addr((pg * 64) + (off & 32'h3C));
        do_ctrl($urandom_range(0, 5) == 0 ? 32'h0 : 32'h1, "R3 mode");
        for (int f = 0; f < int'($urandom_range(0, 18)); f++) do_fill($urandom);
        do_ctrl(32'h5, "R6 random");
      end else if (kind == 1) begin
        do_addr(pg * 64 + ($urandom_range(0, 3) == 0 ? 32'd8 : 32'd0));
        do_ctrl(32'hA, "R8 random");
      end else if (kind == 2) begin
        do_ctrl(32'h1, "R3 mode");
        do_addr(pg * 64);
        for (int f = 0; f < PW; f++) do_fill($urandom);
        do_ctrl(32'h5, "R6 random full");
      end else begin
        clear_err();
      end
      check_state("R6 random state");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule